// File: doc/BRIEF.md
# Programmable Synchronous Serial Channel

This block moves data words over a four-wire synchronous serial link in the style of SPI. In master mode it makes the shift clock itself, from a 16-bit reload value that sets the bit rate. In slave mode it takes the shift clock and an active-low select from an external master. A host loads words through a transmit holding register and collects them from a receive register. Both directions are double-buffered, so the next word can be loaded while the current one is still shifting.

The frame length, the bit order, the idle level of the clock and the clock edge used to sample data are all set through configuration inputs. Single-cycle pulses report three events: a transmit word taken, a receive word ready, and an error. Four error classes are reported separately on a flag vector.

Top module: `spi_serial_channel`

## Requirements
- R1: A frame started in master mode moves the holding word out on `ser_out`. The word seen on `ser_in` lands in `rx_data`. One cycle-wide `irq_rx_full` pulse then marks the word valid, with `rx_valid` set.
- R2: `cfg_len_m1` gives the frame length minus one, from 1 (2 bits) to 15 (16 bits). The value 0 is handled as 2 bits. Bits of `rx_data` above the frame length read as zero.
- R3: With `cfg_lsb_first` = 1, bit 0 of the word travels first. With 0, the top bit of the frame travels first.
- R4: `cfg_cpol` sets the idle level of the shift clock. With `cfg_cpha` = 0, data is sampled on the first (leading) edge of each bit and changed on the second. With `cfg_cpha` = 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: In master mode, `sck_out` toggles once every `cfg_reload`+1 clock cycles. This gives a bit period of 2×(`cfg_reload`+1) cycles.
- R6: A word written while a frame is shifting is held. When the word moves into the shifter, `irq_tx_empty` pulses. A held word starts the next frame directly after the current one ends, and frames arrive in write order.
- R7: `rx_rd` clears `rx_valid` in the next cycle, unless a new word arrives in that same cycle.
- R8: In slave mode, shifting follows the edges of `sck_in` only while `ss_n_in` is low, and `sck_out` stays at the idle level. The word in the holding register goes out on `ser_out`.
- R9: Receive error, `err_flags[0]`: a frame completes while `rx_valid` is still set and is not being read. The new word overwrites the old one.
- R10: Phase error, `err_flags[1]`: in slave mode, `ss_n_in` rises after at least one clock edge of a frame. The frame is dropped and no word is delivered.
- R11: Baud rate error, `err_flags[2]`: in slave mode with the select active, the synchronized `sck_in` changes level in two consecutive cycles.
- R12: Transmit error, `err_flags[3]`: in slave mode, the first clock edge of a frame arrives when no fresh word was in the holding register at frame start. That frame transmits zeros.
- R13: `irq_err` pulses in the same cycle as any non-zero `err_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_cpol | input | 1 | Idle level of the shift clock |
| cfg_cpha | input | 1 | Sample on the trailing edge when 1 |
| cfg_len_m1 | input | LW | Frame length minus one |
| cfg_reload | input | RW | Bit-rate reload value |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | DW | Word to transmit |
| rx_rd | input | 1 | Read acknowledge for the receive register |
| rx_data | output | DW | Last received word |
| rx_valid | output | 1 | Receive register holds an unread word |
| sck_in | input | 1 | Shift clock from an external master |
| ss_n_in | input | 1 | Slave select, active low |
| ser_in | input | 1 | Serial data in |
| sck_out | output | 1 | Shift clock driven in master mode |
| ser_out | output | 1 | Serial data out |
| irq_tx_empty | output | 1 | Holding word moved to the shifter |
| irq_rx_full | output | 1 | New word in the receive register |
| irq_err | output | 1 | Any error this cycle |
| err_flags | output | 4 | Error pulses: receive, phase, baud, transmit |

## Verification
Master frames run in loopback across all four clock modes, both bit orders, and lengths of 2, 8, 12 and 16 bits, including the clamped length code 0. Comparing the bits seen on the wire with the received word separates bit-order faults from sampling-edge faults. Toggle spacing is measured at two reload values to expose divider off-by-one faults. Slave frames are driven by a bit-banged external master in two modes, which checks data in both directions. Deliberately broken sequences then trigger each error class: an unread word, a select released mid-frame, clock edges one cycle apart, and a frame with no transmit data. Each of these shows whether the matching flag is raised for that cause alone.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int ERR_RX = 0;
  localparam int ERR_PH = 1;
  localparam int ERR_BD = 2;
  localparam int ERR_TX = 3;
  localparam int ERR_W  = 4;
endpackage

// File: rtl/ssc_baud_gen.sv
module ssc_baud_gen #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [RW-1:0] reload,
  output logic          tick
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= reload;
    else if (cnt == '0) cnt <= reload;
    else cnt <= cnt - 1'b1;
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/ssc_slave_sync.sv
module ssc_slave_sync (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic sck_in,
  input  logic ss_n_in,
  output logic sck_edge,
  output logic ss_act,
  output logic too_fast
);
  logic [2:0] sck_s;
  logic [1:0] ss_s;
  logic       edge_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s  <= {3{cpol}};
      ss_s   <= 2'b11;
      edge_d <= 1'b0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_in};
      ss_s   <= {ss_s[0], ss_n_in};
      edge_d <= sck_edge;
    end
  end

  assign sck_edge = sck_s[2] ^ sck_s[1];
  assign ss_act   = ~ss_s[1];
  assign too_fast = sck_edge & edge_d;
endmodule

// File: rtl/ssc_shift_core.sv
module ssc_shift_core #(
  parameter int DW = 16,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          lsb_first,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [LW-1:0] len_m1,
  input  logic          hold_vld,
  input  logic [DW-1:0] hold_word,
  input  logic          edge_m,
  input  logic          edge_s,
  input  logic          ss_act,
  input  logic          ser_in,
  output logic          active,
  output logic          take,
  output logic          tx_err,
  output logic          phase_err,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          sck_out,
  output logic          ser_out
);
  localparam int EW = LW + 1;

  logic [LW-1:0] nb_m1;
  logic [EW-1:0] ecnt;
  logic [LW:0]   tptr, rptr;
  logic [DW-1:0] txw, rxw, rx_nxt;
  logic          fresh, edge_c, last, sample, fin, abort, start;

  assign nb_m1 = (len_m1 == '0) ? LW'(1) : len_m1;

  function automatic logic [LW-1:0] pos(input logic [LW:0] p);
    pos = lsb_first ? p[LW-1:0] : nb_m1 - p[LW-1:0];
  endfunction

  assign edge_c = active && (master ? edge_m : edge_s);
  assign last   = (ecnt == {nb_m1, 1'b1});
  assign sample = (ecnt[0] == cpha);
  assign fin    = edge_c && last;
  assign abort  = !master && active && !ss_act;
  assign start  = !abort && (!active || fin) && (master ? hold_vld : ss_act);

  assign take      = start && hold_vld;
  assign tx_err    = !master && edge_c && (ecnt == '0) && !fresh;
  assign phase_err = abort && (ecnt != '0);

  always_comb begin
    rx_nxt = rxw;
    if (edge_c && sample) rx_nxt[pos(rptr)] = ser_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ecnt    <= '0;
      tptr    <= '0;
      rptr    <= '0;
      txw     <= '0;
      rxw     <= '0;
      fresh   <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
      sck_out <= cpol;
      ser_out <= 1'b0;
    end else begin
      done <= fin;
      if (fin) rx_word <= rx_nxt;
      if (!master || !active) sck_out <= cpol;
      else if (edge_c) sck_out <= ~sck_out;
      if (edge_c) begin
        ecnt <= ecnt + 1'b1;
        rxw  <= rx_nxt;
        if (sample) rptr <= rptr + 1'b1;
        else if (tptr <= {1'b0, nb_m1}) begin
          ser_out <= txw[pos(tptr)];
          tptr    <= tptr + 1'b1;
        end
      end
      if (fin || abort) active <= 1'b0;
      if (start) begin
        active <= 1'b1;
        ecnt   <= '0;
        rptr   <= '0;
        rxw    <= '0;
        fresh  <= hold_vld;
        txw    <= hold_vld ? hold_word : '0;
        if (cpha) tptr <= '0;
        else begin
          tptr    <= (LW+1)'(1);
          ser_out <= hold_vld ? hold_word[pos('0)] : 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_serial_channel.sv
module spi_serial_channel #(
  parameter int DW = 16,
  parameter int RW = 16,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_master,
  input  logic          cfg_lsb_first,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic [LW-1:0] cfg_len_m1,
  input  logic [RW-1:0] cfg_reload,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          sck_in,
  input  logic          ss_n_in,
  input  logic          ser_in,
  output logic          sck_out,
  output logic          ser_out,
  output logic          irq_tx_empty,
  output logic          irq_rx_full,
  output logic          irq_err,
  output logic [3:0]    err_flags
);
  import ssc_pkg::*;

  logic          hold_vld, active, take, tx_err, phase_err, done;
  logic          tick, s_edge, ss_act, too_fast, baud_err, rx_err;
  logic [DW-1:0] hold_word, rx_word;
  logic [ERR_W-1:0] err_now;

  ssc_baud_gen #(.RW(RW)) u_baud (
    .clk(clk), .rst(rst), .run(cfg_master && active),
    .reload(cfg_reload), .tick(tick)
  );

  ssc_slave_sync u_sync (
    .clk(clk), .rst(rst), .cpol(cfg_cpol), .sck_in(sck_in),
    .ss_n_in(ss_n_in), .sck_edge(s_edge), .ss_act(ss_act), .too_fast(too_fast)
  );

  ssc_shift_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .master(cfg_master), .lsb_first(cfg_lsb_first),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .len_m1(cfg_len_m1),
    .hold_vld(hold_vld), .hold_word(hold_word), .edge_m(tick), .edge_s(s_edge),
    .ss_act(ss_act), .ser_in(ser_in), .active(active), .take(take),
    .tx_err(tx_err), .phase_err(phase_err), .done(done), .rx_word(rx_word),
    .sck_out(sck_out), .ser_out(ser_out)
  );

  assign baud_err = !cfg_master && ss_act && too_fast;
  assign rx_err   = done && rx_valid && !rx_rd;

  always_comb begin
    err_now         = '0;
    err_now[ERR_RX] = rx_err;
    err_now[ERR_PH] = phase_err;
    err_now[ERR_BD] = baud_err;
    err_now[ERR_TX] = tx_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld     <= 1'b0;
      hold_word    <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      irq_tx_empty <= 1'b0;
      irq_rx_full  <= 1'b0;
      irq_err      <= 1'b0;
      err_flags    <= '0;
    end else begin
      if (tx_wr) begin
        hold_vld  <= 1'b1;
        hold_word <= tx_data;
      end else if (take) hold_vld <= 1'b0;
      if (done) begin
        rx_data  <= rx_word;
        rx_valid <= 1'b1;
      end else if (rx_rd) rx_valid <= 1'b0;
      irq_tx_empty <= take;
      irq_rx_full  <= done;
      err_flags    <= err_now;
      irq_err      <= |err_now;
    end
  end
endmodule

// File: rtl/spi_serial_channel_chk.sv
module spi_serial_channel_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_master,
  input logic       cfg_cpol,
  input logic       rx_rd,
  input logic       rx_valid,
  input logic       sck_out,
  input logic       irq_rx_full,
  input logic [3:0] err_flags
);
  assert_rd_clears_R7: assert property (@(posedge clk) disable iff (rst)
    rx_rd |=> (!rx_valid || irq_rx_full));

  assert_full_valid_R1: assert property (@(posedge clk) disable iff (rst)
    irq_rx_full |-> rx_valid);

  assert_slave_idle_clk_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_master && $past(!cfg_master) && $stable(cfg_cpol)) |-> (sck_out == cfg_cpol));

  assert_tx_err_slave_R12: assert property (@(posedge clk) disable iff (rst)
    err_flags[3] |-> !$past(cfg_master));

  assert_baud_err_slave_R11: assert property (@(posedge clk) disable iff (rst)
    err_flags[2] |-> !$past(cfg_master));
endmodule

bind spi_serial_channel spi_serial_channel_chk u_chk (
  .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
  .rx_rd(rx_rd), .rx_valid(rx_valid), .sck_out(sck_out),
  .irq_rx_full(irq_rx_full), .err_flags(err_flags)
);

// File: tb/spi_serial_channel_tb_top.sv
module spi_serial_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic clk = 0, rst = 1;
  logic cfg_master = 1, cfg_lsb_first = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic [3:0] cfg_len_m1 = 4'd7;
  logic [15:0] cfg_reload = 16'd3;
  logic tx_wr = 0, rd_mon = 0, rd_drv = 0, sck_in = 0, ss_n_in = 1, mosi = 0;
  logic [15:0] tx_data = 0;
  logic [15:0] rx_data;
  logic rx_valid, sck_out, ser_out, irq_tx_empty, irq_rx_full, irq_err;
  logic [3:0] err_flags;
  logic ser_in;

  assign ser_in = cfg_master ? ser_out : mosi;

  spi_serial_channel dut_i (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_len_m1(cfg_len_m1),
    .cfg_reload(cfg_reload), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rd_mon | rd_drv),
    .rx_data(rx_data), .rx_valid(rx_valid), .sck_in(sck_in), .ss_n_in(ss_n_in),
    .ser_in(ser_in), .sck_out(sck_out), .ser_out(ser_out), .irq_tx_empty(irq_tx_empty),
    .irq_rx_full(irq_rx_full), .irq_err(irq_err), .err_flags(err_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, last_t = 0, mon_k = 0;
  int n_txe = 0, n_rxf = 0, n_ie = 0;
  int e_cnt [4] = '{0, 0, 0, 0};
  bit auto_rd = 1, mon_in = 0, finished = 0;
  logic sck_prev = 0;
  logic [15:0] mon_word = 0;
  logic [15:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [3:0] lm1);
    return (lm1 == 0) ? 2 : int'(lm1) + 1;
  endfunction

  function automatic logic [15:0] msk(input logic [15:0] w, input logic [3:0] lm1);
    return w & 16'((32'd1 << nbits(lm1)) - 1);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    rd_mon = 0;
    if (!rst) begin
      if (cfg_master && sck_out != sck_prev && (mon_in || sck_out != cfg_cpol)) begin
        if (mon_in) chk(cyc - last_t == int'(cfg_reload) + 1, "R5", cyc - last_t, int'(cfg_reload) + 1);
        last_t = cyc;
        mon_in = 1;
        if ((sck_out != cfg_cpol) != cfg_cpha) begin // R4 sampling edge
          if (cfg_lsb_first) mon_word[mon_k] = ser_out;
          else mon_word[nbits(cfg_len_m1) - 1 - mon_k] = ser_out;
          mon_k++;
        end
      end
      sck_prev = sck_out;
      if (irq_tx_empty) n_txe++;
      if (irq_err) n_ie++;
      for (int i = 0; i < 4; i++) if (err_flags[i]) e_cnt[i]++;
      if (irq_err) chk(err_flags != 0, "R13", err_flags, 1);
      if (irq_rx_full) begin
        n_rxf++;
        if (exp_q.size() == 0) chk(0, "R10", rx_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R1", rx_data, e);
          if (cfg_master) chk(mon_word == e, "R3", mon_word, e);
        end
        mon_word = 0; mon_k = 0; mon_in = 0;
        if (auto_rd) rd_mon = 1;
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic setcfg(input bit m, input logic [3:0] lm1, input bit lsb, input bit pol,
                        input bit pha, input logic [15:0] rl);
    @(negedge clk);
    cfg_master = m; cfg_len_m1 = lm1; cfg_lsb_first = lsb;
    cfg_cpol = pol; cfg_cpha = pha; cfg_reload = rl; sck_in = pol;
    repeat (5) @(negedge clk);
  endtask

  task automatic mx(input logic [15:0] w, input logic [3:0] lm1, input bit lsb,
                    input bit pol, input bit pha, input logic [15:0] rl);
    setcfg(1, lm1, lsb, pol, pha, rl);
    exp_q.push_back(msk(w, lm1));
    tx_wr = 1; tx_data = w;
    @(negedge clk);
    tx_wr = 0;
    drain();
    chk(sck_out == pol, "R4", sck_out, pol);
  endtask

  task automatic sx(input logic [15:0] din, input logic [15:0] exp_out, input logic [3:0] lm1,
                    input bit lsb, input bit pol, input bit pha, input bit wr,
                    input logic [15:0] tw, input string req);
    int n;
    logic [15:0] got;
    n = nbits(lm1);
    got = 0;
    setcfg(0, lm1, lsb, pol, pha, 0);
    if (wr) begin
      tx_wr = 1; tx_data = tw;
      @(negedge clk);
      tx_wr = 0;
    end
    exp_q.push_back(msk(din, lm1));
    ss_n_in = 0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int bi;
      bi = lsb ? k : n - 1 - k;
      if (!pha) begin
        mosi = din[bi];
        repeat (H) @(negedge clk);
        got[bi] = ser_out;
        sck_in = ~pol;
        repeat (H) @(negedge clk);
        sck_in = pol;
      end else begin
        sck_in = ~pol;
        mosi = din[bi];
        repeat (H) @(negedge clk);
        got[bi] = ser_out;
        sck_in = pol;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    chk(sck_out == pol, "R8", sck_out, pol);
    ss_n_in = 1;
    drain();
    chk(got == exp_out, req, got, exp_out);
  endtask

  initial begin
    int b_e [4];
    int b_rxf;
    repeat (3) @(negedge clk);
    chk(rx_valid == 0 && irq_rx_full == 0 && irq_err == 0 && err_flags == 0, "R1", rx_valid, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(sck_out == 0, "R4", sck_out, 0);

    mx(16'h00A5, 4'd7, 0, 0, 0, 16'd3);   // R3 msb first, mode 0
    mx(16'hBEEF, 4'd15, 1, 1, 1, 16'd0);  // R2 16 bits, R3 lsb first, mode 3
    mx(16'hFFFE, 4'd1, 0, 0, 1, 16'd2);   // R2 2 bits
    mx(16'hFFFF, 4'd0, 1, 1, 0, 16'd1);   // R2 length code 0 -> 2 bits
    mx(16'h5A3C, 4'd11, 1, 1, 0, 16'd1);  // R2 12 bits
    chk(rx_valid == 0, "R7", rx_valid, 0);

    // R6 back-to-back through the holding register
    setcfg(1, 4'd7, 0, 0, 0, 16'd2);
    b_rxf = n_txe;
    exp_q.push_back(16'h0081); exp_q.push_back(16'h007E);
    tx_wr = 1; tx_data = 16'h0081;
    @(negedge clk);
    tx_data = 16'h007E;
    while (n_txe == b_rxf) @(negedge clk);
    @(negedge clk);
    tx_wr = 0;
    drain();
    chk(n_txe - b_rxf == 2, "R6", n_txe - b_rxf, 2);

    // R9 receive overrun, R7 read clears
    auto_rd = 0;
    b_e = e_cnt;
    mx(16'h0011, 4'd7, 0, 0, 0, 16'd0);
    mx(16'h0022, 4'd7, 0, 0, 0, 16'd0);
    chk(e_cnt[0] - b_e[0] == 1, "R9", e_cnt[0] - b_e[0], 1);
    chk(rx_valid == 1 && rx_data == 16'h0022, "R9", rx_data, 16'h0022);
    auto_rd = 1;
    rd_drv = 1;
    @(negedge clk);
    rd_drv = 0;
    @(negedge clk);
    chk(rx_valid == 0, "R7", rx_valid, 0);

    // R8 slave frames
    b_e = e_cnt;
    sx(16'h003C, 16'h0096, 4'd7, 0, 0, 0, 1, 16'h0096, "R8");
    sx(16'h02A7, 16'h0159, 4'd9, 1, 1, 1, 1, 16'h0159, "R8");
    chk(e_cnt[3] == b_e[3] && e_cnt[1] == b_e[1], "R12", e_cnt[3] - b_e[3], 0);

    // R12 slave with no transmit word
    b_e = e_cnt;
    sx(16'h00C3, 16'h0000, 4'd7, 0, 0, 0, 0, 16'h0, "R12");
    chk(e_cnt[3] - b_e[3] == 1, "R12", e_cnt[3] - b_e[3], 1);

    // R10 select released mid-frame
    b_e = e_cnt;
    b_rxf = n_rxf;
    setcfg(0, 4'd7, 0, 0, 0, 0);
    ss_n_in = 0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sck_in = ~sck_in;
      repeat (H) @(negedge clk);
    end
    ss_n_in = 1;
    repeat (10) @(negedge clk);
    chk(e_cnt[1] - b_e[1] == 1, "R10", e_cnt[1] - b_e[1], 1);
    chk(n_rxf == b_rxf, "R10", n_rxf - b_rxf, 0);

    // R11 clock edges one cycle apart
    b_e = e_cnt;
    setcfg(0, 4'd7, 0, 0, 0, 0);
    ss_n_in = 0;
    repeat (H) @(negedge clk);
    sck_in = 1;
    @(negedge clk);
    sck_in = 0;
    repeat (H) @(negedge clk);
    ss_n_in = 1;
    repeat (10) @(negedge clk);
    chk(e_cnt[2] - b_e[2] == 1, "R11", e_cnt[2] - b_e[2], 1);
    chk(n_ie > 0, "R13", n_ie, 1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule